// File: doc/BRIEF.md
# Staged Initialisation Word Loader

This block holds the start-up configuration of a single-phase pulse-width modulation generator. A host writes the 24-bit configuration one byte at a time into three staging bytes over a simple synchronous write port. None of these writes reaches the active configuration. A separate write to a commit address copies all staged bytes into the active register in a single clock edge, so the downstream waveform logic never sees a partly updated word.

The block accepts a commit only while the active-low `halt_n` input is low. That is the state in which the generator's switch outputs are forced off. When a commit is accepted, the block also registers a decoded form of the new word next to the raw fields:
- the carrier clock division ratio,
- the power-frequency range multiplier,
- the pulse-delay length in carrier-counter ticks.

A registered flag tells the host whether an update would currently be accepted. The staging bytes keep their contents after a commit, so the host can edit a single field and commit again.

Top module: `init_cfg_loader`

## Requirements
- R1: Synchronous reset (`rst` high) clears the staging bytes, the active word and `upd_ok` to zero. Because the active word is zero, the decoded outputs read `div_ratio` 1, `range_mult` 1 and `dly_ticks` 64.
- R2: A write with `wr_addr` 0, 1 or 2 stores `wr_data` into staging byte 0, 1 or 2 (byte 0 is bits 7:0 of the word, byte 2 is bits 23:16). Such a write leaves `cfg_word` unchanged.
- R3: A write to address 4 while `halt_n` is low copies all three staging bytes into `cfg_word`, visible after that clock edge. The data value of the commit write is ignored.
- R4: A write to address 4 while `halt_n` is high is ignored, and `cfg_word` keeps its old value.
- R5: Writes to address 3, 5, 6 or 7 change neither the staging bytes nor `cfg_word`.
- R6: Staging bytes keep their value across a commit. Rewriting one byte and committing again changes only that byte of `cfg_word`.
- R7: The field outputs are slices of the active word:
  - `carr_sel` = bits 2:0
  - `range_sel` = bits 5:3
  - `cnt_clr` = bit 6
  - `dly_sel` = bits 13:8
  - `del_sel` = bits 21:16
- R8: `div_ratio` is 2 raised to the power of `carr_sel` for codes 0 to 5. Codes 6 and 7 saturate at 32.
- R9: `range_mult` is 2 raised to the power of `range_sel` for codes 0 to 6. Code 7 saturates at 64.
- R10: `dly_ticks` equals 64 minus `dly_sel`, so code 63 gives 1 and code 0 gives 64.
- R11: `upd_ok` equals the inverse of `halt_n` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_n | input | 1 | Active-low hold; low forces outputs off and permits commits |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| cfg_word | output | 24 | Active configuration word |
| carr_sel | output | 3 | Carrier divider select field |
| range_sel | output | 3 | Frequency range select field |
| dly_sel | output | 6 | Pulse delay select field |
| del_sel | output | 6 | Minimum pulse (deletion) select field |
| cnt_clr | output | 1 | Power frequency counter clear bit |
| div_ratio | output | 6 | Decoded carrier clock division ratio |
| range_mult | output | 7 | Decoded frequency range multiplier |
| dly_ticks | output | 7 | Decoded pulse delay length |
| upd_ok | output | 1 | High when a commit would be accepted |

## Verification
The case hardest to reach from the ports is a write that should have no effect on staging. Staging is not visible until a commit copies it out. The stimulus therefore writes all-ones to each unmapped address and then issues a commit while `halt_n` is low. Any corruption of the staging bytes would show up in `cfg_word`. Commits issued with `halt_n` high are mixed in, as are one-byte edits between commits. The decoders are covered by a sweep of every carrier and range code pair and every delay code, each delivered through a real commit.

// File: rtl/init_cfg_pkg.sv
package init_cfg_pkg;

  localparam int CARR_W  = 3;
  localparam int RANGE_W = 3;
  localparam int DLY_W   = 6;
  localparam int DEL_W   = 6;

  localparam int CARR_LSB  = 0;
  localparam int RANGE_LSB = 3;
  localparam int CLR_BIT   = 6;
  localparam int DLY_LSB   = 8;
  localparam int DEL_LSB   = 16;

  localparam int CARR_MAX_EXP  = 5;
  localparam int RANGE_MAX_EXP = 6;

  localparam int RATIO_W = CARR_MAX_EXP + 1;
  localparam int MULT_W  = RANGE_MAX_EXP + 1;
  localparam int TICK_W  = DLY_W + 1;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [MULT_W-1:0]  mult;
    logic [TICK_W-1:0]  ticks;
  } cfg_dec_t;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [CARR_W-1:0] sel);
    logic [RATIO_W-1:0] r;
    if (int'(sel) >= CARR_MAX_EXP) r = RATIO_W'(1) << CARR_MAX_EXP;
    else                           r = RATIO_W'(1) << sel;
    return r;
  endfunction

  function automatic logic [MULT_W-1:0] mult_of(input logic [RANGE_W-1:0] sel);
    logic [MULT_W-1:0] m;
    if (int'(sel) >= RANGE_MAX_EXP) m = MULT_W'(1) << RANGE_MAX_EXP;
    else                            m = MULT_W'(1) << sel;
    return m;
  endfunction

  function automatic logic [TICK_W-1:0] ticks_of(input logic [DLY_W-1:0] sel);
    return TICK_W'(1 << DLY_W) - {1'b0, sel};
  endfunction

endpackage

// File: rtl/init_stage_bank.sv
module init_stage_bank #(
  parameter int BYTE_W    = 8,
  parameter int NUM_STAGE = 3,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [BYTE_W*NUM_STAGE-1:0] staged
);

  for (genvar i = 0; i < NUM_STAGE; i++) begin : g_byte
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst)      staged[i*BYTE_W +: BYTE_W] <= '0;
      else if (hit) staged[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

endmodule

// File: rtl/init_commit_ctrl.sv
module init_commit_ctrl #(
  parameter int ADDR_W      = 3,
  parameter int COMMIT_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              commit,
  output logic              upd_ok
);

  localparam logic [ADDR_W-1:0] CADDR = ADDR_W'(COMMIT_ADDR);

  assign commit = wr_en && (wr_addr == CADDR) && !halt_n;

  always_ff @(posedge clk) begin
    if (rst) upd_ok <= 1'b0;
    else     upd_ok <= !halt_n;
  end

endmodule

// File: rtl/init_field_decode.sv
module init_field_decode
  import init_cfg_pkg::*;
(
  input  logic [CARR_W-1:0]  carr,
  input  logic [RANGE_W-1:0] range,
  input  logic [DLY_W-1:0]   dly,
  output cfg_dec_t           dec
);

  always_comb begin
    dec.ratio = ratio_of(carr);
    dec.mult  = mult_of(range);
    dec.ticks = ticks_of(dly);
  end

endmodule

// File: rtl/init_cfg_loader.sv
module init_cfg_loader
  import init_cfg_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_STAGE   = 3,
  parameter int ADDR_W      = 3,
  parameter int COMMIT_ADDR = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        halt_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [BYTE_W*NUM_STAGE-1:0] cfg_word,
  output logic [CARR_W-1:0]           carr_sel,
  output logic [RANGE_W-1:0]          range_sel,
  output logic [DLY_W-1:0]            dly_sel,
  output logic [DEL_W-1:0]            del_sel,
  output logic                        cnt_clr,
  output logic [RATIO_W-1:0]          div_ratio,
  output logic [MULT_W-1:0]           range_mult,
  output logic [TICK_W-1:0]           dly_ticks,
  output logic                        upd_ok
);

  localparam int WORD_W = BYTE_W * NUM_STAGE;

  logic [WORD_W-1:0] staged;
  logic              commit;
  cfg_dec_t          dec_next;
  cfg_dec_t          dec_q;
  cfg_dec_t          dec_rst;

  init_stage_bank #(
    .BYTE_W(BYTE_W), .NUM_STAGE(NUM_STAGE), .ADDR_W(ADDR_W)
  ) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .staged(staged)
  );

  init_commit_ctrl #(
    .ADDR_W(ADDR_W), .COMMIT_ADDR(COMMIT_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .halt_n(halt_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .commit(commit), .upd_ok(upd_ok)
  );

  init_field_decode u_dec (
    .carr (staged[CARR_LSB  +: CARR_W]),
    .range(staged[RANGE_LSB +: RANGE_W]),
    .dly  (staged[DLY_LSB   +: DLY_W]),
    .dec  (dec_next)
  );

  always_comb begin
    dec_rst.ratio = ratio_of('0);
    dec_rst.mult  = mult_of('0);
    dec_rst.ticks = ticks_of('0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_word <= '0;
      dec_q    <= dec_rst;
    end else if (commit) begin
      cfg_word <= staged;
      dec_q    <= dec_next;
    end
  end

  assign carr_sel   = cfg_word[CARR_LSB  +: CARR_W];
  assign range_sel  = cfg_word[RANGE_LSB +: RANGE_W];
  assign cnt_clr    = cfg_word[CLR_BIT];
  assign dly_sel    = cfg_word[DLY_LSB   +: DLY_W];
  assign del_sel    = cfg_word[DEL_LSB   +: DEL_W];
  assign div_ratio  = dec_q.ratio;
  assign range_mult = dec_q.mult;
  assign dly_ticks  = dec_q.ticks;

endmodule

// File: rtl/init_cfg_loader_chk.sv
module init_cfg_loader_chk #(
  parameter int ADDR_W      = 3,
  parameter int WORD_W      = 24,
  parameter int COMMIT_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              halt_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] cfg_word,
  input logic              upd_ok,
  input logic [5:0]        div_ratio,
  input logic [6:0]        range_mult,
  input logic [6:0]        dly_ticks
);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(halt_n)) |-> $stable(cfg_word));

  assert_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr_en) && $past(wr_addr) == ADDR_W'(COMMIT_ADDR)))
      |-> $stable(cfg_word));

  assert_flag_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (upd_ok == !$past(halt_n)));

  assert_ratio_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(div_ratio) == 1);

  assert_mult_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(range_mult) == 1);

  assert_ticks_R10: assert property (@(posedge clk) disable iff (rst)
    (dly_ticks != 7'd0) && (dly_ticks <= 7'd64));

endmodule

bind init_cfg_loader init_cfg_loader_chk #(
  .ADDR_W(ADDR_W), .WORD_W(BYTE_W*NUM_STAGE), .COMMIT_ADDR(COMMIT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .halt_n(halt_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg_word(cfg_word), .upd_ok(upd_ok), .div_ratio(div_ratio),
  .range_mult(range_mult), .dly_ticks(dly_ticks)
);

// File: tb/init_cfg_loader_test.sv
`timescale 1ns/1ps
module init_cfg_loader_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] cfg_word;
  logic [2:0]  carr_sel, range_sel;
  logic [5:0]  dly_sel, del_sel;
  logic        cnt_clr;
  logic [5:0]  div_ratio;
  logic [6:0]  range_mult, dly_ticks;
  logic        upd_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0]  st [3];
  logic [23:0] exp_word;

  always #4 clk = ~clk;

  init_cfg_loader uut (
    .clk(clk), .rst(rst), .halt_n(halt_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_word(cfg_word), .carr_sel(carr_sel),
    .range_sel(range_sel), .dly_sel(dly_sel), .del_sel(del_sel),
    .cnt_clr(cnt_clr), .div_ratio(div_ratio), .range_mult(range_mult),
    .dly_ticks(dly_ticks), .upd_ok(upd_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 3) st[a] = d;
    if (a == 3'd4 && !halt_n) exp_word = {st[2], st[1], st[0]};
  endtask

  function automatic int e_ratio(input int c);
    return (c >= 5) ? 32 : (1 << c);
  endfunction
  function automatic int e_mult(input int f);
    return (f >= 6) ? 64 : (1 << f);
  endfunction

  task automatic chk_all(input string tag);
    chk({tag, " word"},  int'(cfg_word),  int'(exp_word));
    chk("R7 carr",  int'(carr_sel),  int'(exp_word[2:0]));
    chk("R7 range", int'(range_sel), int'(exp_word[5:3]));
    chk("R7 clr",   int'(cnt_clr),   int'(exp_word[6]));
    chk("R7 dly",   int'(dly_sel),   int'(exp_word[13:8]));
    chk("R7 del",   int'(del_sel),   int'(exp_word[21:16]));
    chk("R8 ratio", int'(div_ratio), e_ratio(int'(exp_word[2:0])));
    chk("R9 mult",  int'(range_mult), e_mult(int'(exp_word[5:3])));
    chk("R10 ticks", int'(dly_ticks), 64 - int'(exp_word[13:8]));
  endtask

  initial begin
    for (int i = 0; i < 3; i++) st[i] = 8'h00;
    exp_word = '0;
    repeat (3) @(negedge clk);
    chk("R1 word in reset", int'(cfg_word), 0);
    chk("R1 upd_ok in reset", int'(upd_ok), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 after reset");
    chk("R11 flag high hold", int'(upd_ok), 0);

    // R2: staging writes leave the active word alone
    wr(3'd0, 8'hA5); chk("R2 byte0", int'(cfg_word), 0);
    wr(3'd1, 8'h3C); chk("R2 byte1", int'(cfg_word), 0);
    wr(3'd2, 8'h1F); chk("R2 byte2", int'(cfg_word), 0);

    // R4: commit while halt_n high is ignored
    wr(3'd4, 8'h00); chk("R4 commit blocked", int'(cfg_word), 0);

    halt_n = 1'b0;
    @(negedge clk);
    chk("R11 flag low hold", int'(upd_ok), 1);

    // R3: commit copies all bytes, data ignored
    wr(3'd4, 8'hFF);
    chk("R3 commit", int'(cfg_word), 24'h1F3CA5);
    chk_all("R3 fields");
    wr(3'd4, 8'h00);
    chk("R3 data ignored", int'(cfg_word), 24'h1F3CA5);

    // R5: unmapped addresses touch nothing
    for (int a = 3; a < 8; a++) begin
      if (a != 4) begin
        wr(3'(a), 8'hFF);
        chk("R5 no commit", int'(cfg_word), 24'h1F3CA5);
      end
    end
    wr(3'd4, 8'h5A);
    chk("R5 staging intact", int'(cfg_word), 24'h1F3CA5);

    // R6: edit one byte and recommit
    wr(3'd1, 8'h2A);
    wr(3'd4, 8'h00);
    chk("R6 single byte edit", int'(cfg_word), 24'h1F2AA5);

    // R8/R9/R7: sweep carrier and range codes
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 8; f++) begin
        wr(3'd0, {1'b1, 1'(c ^ f), 3'(f), 3'(c)});
        wr(3'd4, 8'(c * 8 + f));
        chk_all("R8 R9 sweep");
      end
    end

    // R10: sweep delay codes with deletion field alongside
    for (int p = 0; p < 64; p++) begin
      wr(3'd1, 8'(p));
      wr(3'd2, 8'(63 - p));
      wr(3'd4, 8'h00);
      chk_all("R10 sweep");
    end

    // R4/R11: back to running, a commit is refused
    halt_n = 1'b1;
    @(negedge clk);
    chk("R11 flag drops", int'(upd_ok), 0);
    begin
      logic [23:0] held;
      held = exp_word;
      wr(3'd0, 8'h77);
      wr(3'd4, 8'h00);
      chk("R4 running commit ignored", int'(cfg_word), int'(held));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule